// File: doc/BRIEF.md
# Slave Parallel Configuration Port

This block is a synchronous slave port through which an external master either streams a configuration bitstream into the device or reaches a small debug register file. On every rising clock edge where the active-high select is high, the port decodes a 2-bit access kind and acts on the 16-bit write data. The kinds are: set the debug address, read the addressed debug register, write the addressed debug register, or push one configuration word. Debug access is indirect. An address access loads a pointer, and the following read or write uses that pointer.

A mode code is captured while hard reset is held and stays frozen afterwards. It selects 8-bit width, 16-bit width, or an inactive port. The first configuration word after reset carries the bitstream identifier. Further words are forwarded to the configuration sink only if that identifier equals the device identifier input or is the all-ones broadcast value. Detected errors produce one-cycle pulses on two outputs, an error line and a trigger line, and each line has its own mask held in the debug register file. A synchronous soft reset clears all port state except the captured mode.

Top module: `cfg_slave_port`

## Requirements
- R1: An access takes place only at a rising clock edge where `sel_i` is high. With `sel_i` low, no kind of access changes state or raises `cfg_we_o`, `rvalid_o`, `err_o` or `trig_o`.
- R2: `kind_i` is decoded as 2'b00 = load debug address, 2'b01 = debug read, 2'b10 = debug write, 2'b11 = configuration word.
- R3: `rvalid_o` is high for exactly the one cycle after the edge that sampled a debug read, with `rdata_o` valid in that cycle. It is low in every other cycle.
- R4: The address register resets to 0. A debug read or write acts on the register named by the most recent address access. The register map is: 0 = error mask, 1 = trigger mask, 2 = scratch, NREG-1 (3) = read-only status. Writes to the status address are ignored.
- R5: Mode 3'b100 is 8-bit width. In that mode only `wdata_i[7:0]` is used (upper bits are taken as zero), and `rdata_o[15:8]` reads zero. Mode 3'b101 uses the full 16 bits.
- R6: The mode code is sampled only on clock edges while `hard_rst_ni` is low, and is held after release. Any code other than 3'b100 or 3'b101 makes the port ignore all accesses.
- R7: After reset, bits [3:0] of the first configuration word are the bitstream identifier, and that word is not forwarded. If the identifier equals `dev_id_i` or equals 4'hF, each later configuration word appears on `cfg_wdata_o` with `cfg_we_o` high in the cycle after its edge.
- R8: On an identifier mismatch, error 0 fires after the first word. Every later configuration word is dropped and fires error 2.
- R9: A debug read or write while the address is NREG or above fires error 1, and such a read returns zero.
- R10: `err_o` (or `trig_o`) pulses high for one cycle after any error whose bit is clear in the error mask (or trigger mask) register.
- R11: Holding `soft_rst_ni` low at an edge clears the address, the debug registers and the identifier state, and blocks access at that edge. The captured mode is kept.
- R12: Status register bits: [3:0] = captured bitstream identifier, bit 4 = identifier accepted, bit 5 = identifier rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| hard_rst_ni | input | 1 | Asynchronous active-low hard reset; mode is sampled while low |
| soft_rst_ni | input | 1 | Synchronous active-low soft reset of port state |
| mode_i | input | 3 | Mode code (3'b100 8-bit, 3'b101 16-bit, others inactive) |
| dev_id_i | input | 4 | Device identifier compared with the bitstream identifier |
| sel_i | input | 1 | Active-high access select |
| kind_i | input | 2 | Access kind |
| wdata_i | input | 16 | Write data / address |
| rdata_o | output | 16 | Debug read data |
| rvalid_o | output | 1 | Read data valid strobe |
| cfg_we_o | output | 1 | Configuration word write strobe |
| cfg_wdata_o | output | 16 | Configuration word toward the sink |
| err_o | output | 1 | Masked error pulse |
| trig_o | output | 1 | Masked trigger pulse |

## Verification
Every result passes through exactly one register. Read data, the data-valid strobe, the sink strobe and both error pulses are therefore due in the cycle that follows the edge that sampled the access, and they drop one cycle later. The bench drives each access at a falling edge and checks the outputs at the next falling edge, which lies halfway into the cycle where the result is due. Effects carried in state are checked one access later: a debug write is confirmed with a read two accesses on, and identifier acceptance is confirmed through the status register or through the next configuration word.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        ACC_ADDR  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_CONF  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        IDS_WAIT = 2'b00,
        IDS_OK   = 2'b01,
        IDS_BAD  = 2'b10
    } id_state_e;

    localparam logic [2:0] MODE_NARROW = 3'b100;
    localparam logic [2:0] MODE_WIDE   = 3'b101;

    localparam int unsigned NUM_ERR      = 3;
    localparam int unsigned ERR_ID_BAD   = 0;
    localparam int unsigned ERR_ADDR_BAD = 1;
    localparam int unsigned ERR_DROPPED  = 2;

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic              sel_i,
    input  logic [1:0]        kind_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [2:0]        mode_i,
    input  logic              soft_rst_ni,
    output logic              narrow_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              do_addr_o,
    output logic              do_read_o,
    output logic              do_write_o,
    output logic              do_conf_o
);

    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic      port_on;
    logic      take;
    acc_kind_e kind;

    always_comb begin
        kind     = acc_kind_e'(kind_i);
        narrow_o = (mode_i == MODE_NARROW);
        port_on  = soft_rst_ni && ((mode_i == MODE_NARROW) || (mode_i == MODE_WIDE));
        take     = port_on && sel_i;
        wdata_o  = narrow_o ? (wdata_i & NARROW_MASK) : wdata_i;

        do_addr_o  = take && (kind == ACC_ADDR);
        do_read_o  = take && (kind == ACC_READ);
        do_write_o = take && (kind == ACC_WRITE);
        do_conf_o  = take && (kind == ACC_CONF);
    end

endmodule

// File: rtl/cfgp_id_gate.sv
module cfgp_id_gate
    import cfgp_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ID_W   = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_ni,
    input  logic              do_conf_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ID_W-1:0]   dev_id_i,
    output logic              cfg_we_o,
    output logic [DATA_W-1:0] cfg_wdata_o,
    output logic              ev_id_bad_o,
    output logic              ev_drop_o,
    output id_state_e         state_o,
    output logic [ID_W-1:0]   bs_id_o
);

    localparam logic [ID_W-1:0] ID_BCAST = '1;

    typedef struct packed {
        id_state_e         st;
        logic [ID_W-1:0]   bs_id;
        logic              we;
        logic [DATA_W-1:0] wd;
    } gate_t;

    localparam gate_t GATE_RST = '{st: IDS_WAIT, bs_id: '0, we: 1'b0, wd: '0};

    gate_t           gate_d, gate_q;
    logic [ID_W-1:0] hdr_id;
    logic            hdr_ok;

    always_comb begin
        gate_d      = gate_q;
        gate_d.we   = 1'b0;
        ev_id_bad_o = 1'b0;
        ev_drop_o   = 1'b0;
        hdr_id      = wdata_i[ID_W-1:0];
        hdr_ok      = (hdr_id == dev_id_i) || (hdr_id == ID_BCAST);

        if (!clr_ni) begin
            gate_d = GATE_RST;
        end else if (do_conf_i) begin
            case (gate_q.st)
                IDS_WAIT: begin
                    gate_d.bs_id = hdr_id;
                    if (hdr_ok) begin
                        gate_d.st = IDS_OK;
                    end else begin
                        gate_d.st   = IDS_BAD;
                        ev_id_bad_o = 1'b1;
                    end
                end
                IDS_OK: begin
                    gate_d.we = 1'b1;
                    gate_d.wd = wdata_i;
                end
                default: begin
                    ev_drop_o = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gate_q <= GATE_RST;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign cfg_we_o    = gate_q.we;
    assign cfg_wdata_o = gate_q.wd;
    assign state_o     = gate_q.st;
    assign bs_id_o     = gate_q.bs_id;

endmodule

// File: rtl/cfgp_dbg_regs.sv
module cfgp_dbg_regs
    import cfgp_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NARROW_W = 8,
    parameter int unsigned ID_W     = 4,
    parameter int unsigned NREG     = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clr_ni,
    input  logic               narrow_i,
    input  logic               do_addr_i,
    input  logic               do_read_i,
    input  logic               do_write_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  id_state_e          id_state_i,
    input  logic [ID_W-1:0]    bs_id_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               rvalid_o,
    output logic [NUM_ERR-1:0] err_mask_o,
    output logic [NUM_ERR-1:0] trig_mask_o,
    output logic               ev_addr_bad_o
);

    localparam int unsigned NWR       = NREG - 1;
    localparam int unsigned STAT_ADDR = NREG - 1;
    localparam logic [DATA_W-1:0] NARROW_MASK =
        {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0]          addr;
        logic [NWR-1:0][DATA_W-1:0] regs;
        logic                       rvalid;
        logic [DATA_W-1:0]          rdata;
    } dbg_t;

    localparam dbg_t DBG_RST = '{addr: '0, regs: '0, rvalid: 1'b0, rdata: '0};

    dbg_t              dbg_d, dbg_q;
    logic [NWR-1:0]    wr_hit;
    logic              in_range;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] sel_word;

    for (genvar gi = 0; gi < NWR; gi++) begin : g_hit
        assign wr_hit[gi] = do_write_i && (dbg_q.addr == DATA_W'(gi));
    end

    always_comb begin
        stat_word           = '0;
        stat_word[ID_W-1:0] = bs_id_i;
        stat_word[ID_W]     = (id_state_i == IDS_OK);
        stat_word[ID_W+1]   = (id_state_i == IDS_BAD);

        in_range = (dbg_q.addr < DATA_W'(NREG));
        sel_word = '0;
        for (int i = 0; i < NWR; i++) begin
            if (dbg_q.addr == DATA_W'(i)) begin
                sel_word = dbg_q.regs[i];
            end
        end
        if (dbg_q.addr == DATA_W'(STAT_ADDR)) begin
            sel_word = stat_word;
        end
        if (narrow_i) begin
            sel_word = sel_word & NARROW_MASK;
        end

        ev_addr_bad_o = (do_read_i || do_write_i) && !in_range;

        dbg_d        = dbg_q;
        dbg_d.rvalid = do_read_i;
        dbg_d.rdata  = (do_read_i && in_range) ? sel_word : '0;
        if (do_addr_i) begin
            dbg_d.addr = wdata_i;
        end
        for (int i = 0; i < NWR; i++) begin
            if (wr_hit[i]) begin
                dbg_d.regs[i] = wdata_i;
            end
        end
        if (!clr_ni) begin
            dbg_d = DBG_RST;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dbg_q <= DBG_RST;
        end else begin
            dbg_q <= dbg_d;
        end
    end

    assign rdata_o     = dbg_q.rdata;
    assign rvalid_o    = dbg_q.rvalid;
    assign err_mask_o  = dbg_q.regs[0][NUM_ERR-1:0];
    assign trig_mask_o = dbg_q.regs[1][NUM_ERR-1:0];

endmodule

// File: rtl/cfgp_err_pulse.sv
module cfgp_err_pulse #(
    parameter int unsigned N = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_ni,
    input  logic [N-1:0] ev_i,
    input  logic [N-1:0] mask_i,
    output logic         pulse_o
);

    logic pulse_d, pulse_q;

    always_comb begin
        pulse_d = clr_ni && |(ev_i & ~mask_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/cfg_slave_port.sv
module cfg_slave_port
    import cfgp_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NARROW_W = 8,
    parameter int unsigned ID_W     = 4,
    parameter int unsigned NREG     = 4
) (
    input  logic              clk_i,
    input  logic              hard_rst_ni,
    input  logic              soft_rst_ni,
    input  logic [2:0]        mode_i,
    input  logic [ID_W-1:0]   dev_id_i,
    input  logic              sel_i,
    input  logic [1:0]        kind_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              cfg_we_o,
    output logic [DATA_W-1:0] cfg_wdata_o,
    output logic              err_o,
    output logic              trig_o
);

    logic [2:0]         mode_d, mode_q;
    logic               narrow;
    logic [DATA_W-1:0]  wdata_eff;
    logic               do_addr, do_read, do_write, do_conf;
    logic               ev_id_bad, ev_drop, ev_addr_bad;
    logic [NUM_ERR-1:0] ev_vec;
    logic [NUM_ERR-1:0] err_mask, trig_mask;
    id_state_e          id_state;
    logic [ID_W-1:0]    bs_id;

    // Mode follows the pins only while hard reset is held.
    always_comb begin
        mode_d = hard_rst_ni ? mode_q : mode_i;
    end

    always_ff @(posedge clk_i) begin
        mode_q <= mode_d;
    end

    cfgp_decode #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) decode_i (
        .sel_i       (sel_i),
        .kind_i      (kind_i),
        .wdata_i     (wdata_i),
        .mode_i      (mode_q),
        .soft_rst_ni (soft_rst_ni),
        .narrow_o    (narrow),
        .wdata_o     (wdata_eff),
        .do_addr_o   (do_addr),
        .do_read_o   (do_read),
        .do_write_o  (do_write),
        .do_conf_o   (do_conf)
    );

    cfgp_id_gate #(
        .DATA_W (DATA_W),
        .ID_W   (ID_W)
    ) id_gate_i (
        .clk_i       (clk_i),
        .rst_ni      (hard_rst_ni),
        .clr_ni      (soft_rst_ni),
        .do_conf_i   (do_conf),
        .wdata_i     (wdata_eff),
        .dev_id_i    (dev_id_i),
        .cfg_we_o    (cfg_we_o),
        .cfg_wdata_o (cfg_wdata_o),
        .ev_id_bad_o (ev_id_bad),
        .ev_drop_o   (ev_drop),
        .state_o     (id_state),
        .bs_id_o     (bs_id)
    );

    cfgp_dbg_regs #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .ID_W     (ID_W),
        .NREG     (NREG)
    ) dbg_regs_i (
        .clk_i         (clk_i),
        .rst_ni        (hard_rst_ni),
        .clr_ni        (soft_rst_ni),
        .narrow_i      (narrow),
        .do_addr_i     (do_addr),
        .do_read_i     (do_read),
        .do_write_i    (do_write),
        .wdata_i       (wdata_eff),
        .id_state_i    (id_state),
        .bs_id_i       (bs_id),
        .rdata_o       (rdata_o),
        .rvalid_o      (rvalid_o),
        .err_mask_o    (err_mask),
        .trig_mask_o   (trig_mask),
        .ev_addr_bad_o (ev_addr_bad)
    );

    always_comb begin
        ev_vec               = '0;
        ev_vec[ERR_ID_BAD]   = ev_id_bad;
        ev_vec[ERR_ADDR_BAD] = ev_addr_bad;
        ev_vec[ERR_DROPPED]  = ev_drop;
    end

    cfgp_err_pulse #(.N(NUM_ERR)) err_pulse_i (
        .clk_i   (clk_i),
        .rst_ni  (hard_rst_ni),
        .clr_ni  (soft_rst_ni),
        .ev_i    (ev_vec),
        .mask_i  (err_mask),
        .pulse_o (err_o)
    );

    cfgp_err_pulse #(.N(NUM_ERR)) trig_pulse_i (
        .clk_i   (clk_i),
        .rst_ni  (hard_rst_ni),
        .clr_ni  (soft_rst_ni),
        .ev_i    (ev_vec),
        .mask_i  (trig_mask),
        .pulse_o (trig_o)
    );

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
    import cfgp_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NARROW_W = 8
) (
    input logic              clk_i,
    input logic              hard_rst_ni,
    input logic              soft_rst_ni,
    input logic              sel_i,
    input logic [1:0]        kind_i,
    input logic [2:0]        mode_q,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rvalid_o,
    input logic              cfg_we_o,
    input logic [DATA_W-1:0] cfg_wdata_o,
    input logic              err_o,
    input logic              trig_o
);

    logic mode_live;
    assign mode_live = (mode_q == MODE_NARROW) || (mode_q == MODE_WIDE);

    a_r3_rvalid_follows_read: assert property (@(posedge clk_i) disable iff (!hard_rst_ni)
        (sel_i && kind_i == 2'b01 && soft_rst_ni && mode_live) |=> rvalid_o);

    a_r3_rvalid_needs_read: assert property (@(posedge clk_i) disable iff (!hard_rst_ni)
        rvalid_o |-> $past(sel_i && kind_i == 2'b01));

    a_r1_we_needs_conf: assert property (@(posedge clk_i) disable iff (!hard_rst_ni)
        cfg_we_o |-> $past(sel_i && kind_i == 2'b11));

    a_r10_err_needs_access: assert property (@(posedge clk_i) disable iff (!hard_rst_ni)
        err_o |-> $past(sel_i));

    a_r10_trig_needs_access: assert property (@(posedge clk_i) disable iff (!hard_rst_ni)
        trig_o |-> $past(sel_i));

    a_r5_narrow_rdata: assert property (@(posedge clk_i) disable iff (!hard_rst_ni)
        (rvalid_o && mode_q == MODE_NARROW) |-> (rdata_o[DATA_W-1:NARROW_W] == '0));

    a_r5_narrow_cfg: assert property (@(posedge clk_i) disable iff (!hard_rst_ni)
        (cfg_we_o && mode_q == MODE_NARROW) |-> (cfg_wdata_o[DATA_W-1:NARROW_W] == '0));

    a_r6_mode_held: assert property (@(posedge clk_i) disable iff (!hard_rst_ni)
        $past(hard_rst_ni) |-> $stable(mode_q));

    a_r11_soft_quiet: assert property (@(posedge clk_i) disable iff (!hard_rst_ni)
        !soft_rst_ni |=> (!rvalid_o && !cfg_we_o && !err_o && !trig_o));

endmodule

bind cfg_slave_port cfgp_checker #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W)
) chk_i (
    .clk_i       (clk_i),
    .hard_rst_ni (hard_rst_ni),
    .soft_rst_ni (soft_rst_ni),
    .sel_i       (sel_i),
    .kind_i      (kind_i),
    .mode_q      (mode_q),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o),
    .cfg_we_o    (cfg_we_o),
    .cfg_wdata_o (cfg_wdata_o),
    .err_o       (err_o),
    .trig_o      (trig_o)
);

// File: tb/cfg_slave_port_tb_top.sv
module cfg_slave_port_tb_top;

    localparam logic [3:0] DEV_ID = 4'h6;

    logic        clk = 1'b0;
    logic        hard_rst_n = 1'b0;
    logic        soft_rst_n = 1'b1;
    logic [2:0]  mode = 3'b101;
    logic        sel = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        rvalid;
    logic        cfg_we;
    logic [15:0] cfg_wdata;
    logic        err;
    logic        trig;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfg_slave_port dut_i (
        .clk_i       (clk),
        .hard_rst_ni (hard_rst_n),
        .soft_rst_ni (soft_rst_n),
        .mode_i      (mode),
        .dev_id_i    (DEV_ID),
        .sel_i       (sel),
        .kind_i      (kind),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .rvalid_o    (rvalid),
        .cfg_we_o    (cfg_we),
        .cfg_wdata_o (cfg_wdata),
        .err_o       (err),
        .trig_o      (trig)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; on return the next falling edge has passed,
    // so the registered results of this access are on the outputs.
    task automatic acc(input logic [1:0] k, input logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; kind = k; wdata = d;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic dbg_write(input logic [15:0] a, input logic [15:0] d);
        acc(2'b00, a);
        acc(2'b10, d);
    endtask

    task automatic dbg_read(input logic [15:0] a);
        acc(2'b00, a);
        acc(2'b01, 16'h0);
    endtask

    task automatic do_hard_reset(input logic [2:0] m);
        @(negedge clk);
        hard_rst_n = 1'b0; mode = m; sel = 1'b0;
        repeat (3) @(negedge clk);
        hard_rst_n = 1'b1;
    endtask

    task automatic do_soft_reset;
        @(negedge clk);
        soft_rst_n = 1'b0;
        @(negedge clk);
        soft_rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_hard_reset(3'b101);
        @(negedge clk);
        check("R3 reset rvalid", rvalid, 0);
        check("R7 reset cfg_we", cfg_we, 0);
        check("R10 reset err/trig", {err, trig}, 0);

        // R4: address resets to zero, error mask resets to zero
        acc(2'b01, 16'h0);
        check("R4 reset address read", {rvalid, rdata}, {1'b1, 16'h0000});

        // R6: changing mode pins after release has no effect
        mode = 3'b010;

        // R2 R4: write/read sweep over writable registers
        for (int a = 0; a < 3; a++) dbg_write(16'(a), 16'hA5C0 ^ 16'(a * 16'h1111));
        for (int a = 0; a < 3; a++) begin
            dbg_read(16'(a));
            check("R2 R4 readback", {rvalid, rdata}, {1'b1, 16'hA5C0 ^ 16'(a * 16'h1111)});
            check("R6 mode held after pin change", rvalid, 1);
        end
        dbg_write(16'd3, 16'hFFFF);
        dbg_read(16'd3);
        check("R4 R12 status ignores write", rdata, 16'h0000);
        dbg_write(16'd0, 16'h0);
        dbg_write(16'd1, 16'h0);

        // R3: strobe lasts one cycle only
        acc(2'b01, 16'h0);
        @(negedge clk);
        check("R3 rvalid one cycle", rvalid, 0);

        // R1: no access of any kind with select low
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            sel = 1'b0; kind = 2'(k); wdata = 16'h000F;
            @(negedge clk);
            check("R1 select low quiet", {rvalid, cfg_we, err, trig}, 4'b0000);
        end
        dbg_read(16'd3);
        check("R1 no header taken with select low", rdata, 16'h0000);

        // R9: out-of-range addresses
        for (int a = 4; a < 8; a++) begin
            dbg_read(16'(a));
            check("R9 bad address read", {rvalid, rdata, err, trig}, {1'b1, 16'h0000, 1'b1, 1'b1});
        end
        dbg_write(16'h0040, 16'h1234);
        check("R9 bad address write", {err, trig}, 2'b11);

        // R10: mask sweep on the address error (bit 1)
        for (int m = 0; m < 8; m++) begin
            dbg_write(16'd0, 16'(m));
            dbg_write(16'd1, 16'(~m & 7));
            dbg_read(16'd5);
            check("R10 error mask", err, logic'(((m >> 1) & 1) == 0));
            check("R10 trigger mask", trig, logic'(((m >> 1) & 1) == 1));
        end

        // R7 R8 R12: header identifier sweep
        for (int id = 0; id < 16; id++) begin
            bit ok;
            ok = (id == 6) || (id == 15);
            do_soft_reset();
            acc(2'b11, 16'h0A00 | 16'(id));
            check("R7 header not forwarded", cfg_we, 0);
            check("R8 mismatch error", err, !ok);
            acc(2'b11, 16'h5A30 + 16'(id));
            check("R7 R8 word forwarded if accepted", cfg_we, ok);
            if (ok) check("R7 word data", cfg_wdata, 16'h5A30 + 16'(id));
            check("R8 drop error", err, !ok);
            dbg_read(16'd3);
            check("R12 status", rdata, {10'h0, !ok, ok, 4'(id)});
        end

        // R11: soft reset clears registers, keeps 16-bit mode
        dbg_write(16'd2, 16'hBEEF);
        do_soft_reset();
        acc(2'b01, 16'h0);
        check("R11 address and reg0 cleared", rdata, 16'h0000);
        dbg_read(16'd2);
        check("R11 scratch cleared", rdata, 16'h0000);
        dbg_write(16'd2, 16'hBEEF);
        dbg_read(16'd2);
        check("R11 mode kept (16-bit)", rdata, 16'hBEEF);
        @(negedge clk);
        sel = 1'b1; kind = 2'b01; soft_rst_n = 1'b0;
        @(negedge clk);
        sel = 1'b0; soft_rst_n = 1'b1;
        check("R11 access blocked in soft reset", rvalid, 0);

        // R5: narrow mode
        do_hard_reset(3'b100);
        dbg_write(16'd2, 16'hABCD);
        dbg_read(16'h0102);
        check("R5 narrow address and read", {rvalid, rdata, err}, {1'b1, 16'h00CD, 1'b0});
        acc(2'b11, 16'h1206);
        acc(2'b11, 16'hFFEE);
        check("R5 narrow config word", {cfg_we, cfg_wdata}, {1'b1, 16'h00EE});

        // R6: inactive mode codes ignore every access
        for (int m = 0; m < 8; m++) begin
            if (m == 4 || m == 5) continue;
            do_hard_reset(3'(m));
            acc(2'b11, 16'h0006);
            acc(2'b11, 16'h1111);
            check("R6 inactive mode no write", cfg_we, 0);
            dbg_read(16'd7);
            check("R6 inactive mode no read/error", {rvalid, err, trig}, 3'b000);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule